// File: doc/BRIEF.md
# Drive status and seek result tracker

This block holds the per-unit result state of a four-unit floppy disk controller and forms the result bytes for the four commands that report drive state: sense drive status, seek, recalibrate and sense interrupt status. The command sequencer hands it one decoded command at a time. Each command carries an opcode, a unit number, a head bit and, for seek, a target cylinder. The board supplies three per-unit masks: which units are equipped, which hold media, and which media are write-protected.

Seek and recalibrate produce no bytes at once. They store a pending status for the unit they address and, when the drive can move, set that unit's track register to the target cylinder in one step. A later sense interrupt status scans the units from lowest to highest number and returns the first pending status with its track value, then clears it. When nothing is pending it returns a single invalid-command byte and pulses a request to drop the controller interrupt. Sense drive status returns one byte built from the drive's present condition.

Top module: `fdst_tracker`

## Requirements
- R1: After reset no result is presented, no interrupt-clear pulse is given, every pending status is zero and every track register is zero.
- R2: Opcodes on `cmd_op` are 0 sense drive status, 1 seek, 2 recalibrate, 3 sense interrupt status. A command accepted at a clock edge with `cmd_valid` high shows its result bytes on the next edge, with `res_valid` high for exactly that one cycle. Seek and recalibrate raise no `res_valid`.
- R3: Every result status byte has the unit in bits 1:0 and the head in bit 2.
- R4: Sense drive status on an equipped unit returns one byte with bit 3 set, bit 4 set when its track register is zero, bit 5 set when media is present and bit 6 set when the media is write-protected. Bit 7 is clear.
- R5: Sense drive status on a unit outside the equipped mask returns one byte with bit 7 set and bits 6:3 clear.
- R6: Seek to an equipped unit holding media sets its track register to `cmd_cyl` and its pending status to the base byte with bit 5 (seek end) set.
- R7: Seek to an unequipped unit, or to an equipped unit without media, stores the base byte with bits 5, 3 (not ready) and 6 (abnormal end) set, and leaves the track register unchanged.
- R8: Recalibrate to an equipped unit holding media sets its track register to 0 and stores the base byte with bit 5.
- R9: Recalibrate to an equipped unit without media stores the base byte with bits 5 and 3 only. On an unequipped unit it stores bits 5, 3 and 6. In both cases the track register is kept.
- R10: Sense interrupt status returns two bytes when some unit has a nonzero pending status. Byte 0 is the pending status of the lowest-numbered such unit and byte 1 is its track register. That unit's pending status becomes zero.
- R11: Sense interrupt status with no pending status returns the single byte 0x80 and pulses `irq_clear` high for that same one cycle. `irq_clear` is never high at any other time.
- R12: A new seek or recalibrate to a unit replaces any pending status that unit still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Opcode, encoding given in R2 |
| cmd_unit | input | 2 | Addressed unit |
| cmd_head | input | 1 | Addressed head |
| cmd_cyl | input | 8 | Target cylinder for seek |
| equip_mask | input | 4 | Bit per unit: drive fitted |
| media_present | input | 4 | Bit per unit: medium inserted |
| write_prot | input | 4 | Bit per unit: medium write-protected |
| res_valid | output | 1 | Result bytes are valid this cycle |
| res_count | output | 2 | Number of valid result bytes (1 or 2) |
| res_byte0 | output | 8 | First result byte |
| res_byte1 | output | 8 | Second result byte (track value) |
| irq_clear | output | 1 | Pulse: drop the controller interrupt request |

## Verification
The embedded assertions check on every cycle that results come one cycle after a command and last one cycle, that a byte count of two always carries a seek-end status, that the interrupt-clear pulse comes only with the lone 0x80 byte, and that a movable seek lands the track register on the target in one step. The lowest-unit-first scan order, the clearing of a status once read, the replacement of a stale status, and the bit pattern for every mix of equipped, media and write-protect flags can only be shown by the bench scenarios, which compare each result against an independent model.

// File: rtl/fdst_pkg.sv
package fdst_pkg;

    typedef enum logic [1:0] {
        OP_DRV_STAT = 2'd0,
        OP_SEEK     = 2'd1,
        OP_RECAL    = 2'd2,
        OP_INT_STAT = 2'd3
    } fdst_op_e;

    localparam logic [7:0] ST_ABNORMAL  = 8'h40;
    localparam logic [7:0] ST_SEEK_END  = 8'h20;
    localparam logic [7:0] ST_NOT_READY = 8'h08;

    localparam logic [7:0] DS_FAULT     = 8'h80;
    localparam logic [7:0] DS_WPROT     = 8'h40;
    localparam logic [7:0] DS_READY     = 8'h20;
    localparam logic [7:0] DS_TRACK0    = 8'h10;
    localparam logic [7:0] DS_TWO_SIDE  = 8'h08;

    localparam logic [7:0] INVALID_CMD  = 8'h80;

endpackage

// File: rtl/fdst_drive_status.sv
module fdst_drive_status
    import fdst_pkg::*;
(
    input  logic [7:0] base,
    input  logic       equipped,
    input  logic       media,
    input  logic       wprot,
    input  logic       trk_zero,
    output logic [7:0] status
);
    always_comb begin
        status = base;
        if (equipped) begin
            status = status | DS_TWO_SIDE;
            if (trk_zero) status = status | DS_TRACK0;
            if (media)    status = status | DS_READY;
            if (wprot)    status = status | DS_WPROT;
        end else begin
            status = status | DS_FAULT;
        end
    end
endmodule

// File: rtl/fdst_seek_eval.sv
module fdst_seek_eval
    import fdst_pkg::*;
(
    input  logic [7:0] base,
    input  logic       is_recal,
    input  logic       equipped,
    input  logic       media,
    output logic [7:0] pend,
    output logic       move
);
    always_comb begin
        pend = base | ST_SEEK_END;
        move = 1'b0;
        if (!equipped) begin
            pend = pend | ST_NOT_READY | ST_ABNORMAL;
        end else if (!media) begin
            // recalibrate flags only not-ready; seek treats it as unequipped
            pend = is_recal ? (pend | ST_NOT_READY)
                            : (pend | ST_NOT_READY | ST_ABNORMAL);
        end else begin
            move = 1'b1;
        end
    end
endmodule

// File: rtl/fdst_unit_scan.sv
module fdst_unit_scan #(
    parameter int NUM_UNITS = 4,
    localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic [NUM_UNITS-1:0][7:0] pend,
    output logic                      found,
    output logic [UNIT_W-1:0]         idx
);
    logic [NUM_UNITS-1:0] busy;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_busy
        assign busy[g] = |pend[g];
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        // highest first so the lowest-numbered unit wins
        for (int i = NUM_UNITS - 1; i >= 0; i--) begin
            if (busy[i]) begin
                found = 1'b1;
                idx   = UNIT_W'(i);
            end
        end
    end
endmodule

// File: rtl/fdst_tracker.sv
module fdst_tracker
    import fdst_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int CYL_W     = 8,
    localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [UNIT_W-1:0]    cmd_unit,
    input  logic                 cmd_head,
    input  logic [CYL_W-1:0]     cmd_cyl,
    input  logic [NUM_UNITS-1:0] equip_mask,
    input  logic [NUM_UNITS-1:0] media_present,
    input  logic [NUM_UNITS-1:0] write_prot,
    output logic                 res_valid,
    output logic [1:0]           res_count,
    output logic [7:0]           res_byte0,
    output logic [7:0]           res_byte1,
    output logic                 irq_clear
);
    typedef struct packed {
        logic [NUM_UNITS-1:0][7:0]       pend;
        logic [NUM_UNITS-1:0][CYL_W-1:0] trk;
        logic                            vld;
        logic [1:0]                      cnt;
        logic [7:0]                      b0;
        logic [7:0]                      b1;
        logic                            iclr;
    } state_t;

    state_t st_d, st_q;

    logic [7:0]        base_w;
    logic [7:0]        drv_stat_w;
    logic [7:0]        seek_pend_w;
    logic              seek_move_w;
    logic              scan_found_w;
    logic [UNIT_W-1:0] scan_idx_w;
    fdst_op_e          op_w;

    assign op_w   = fdst_op_e'(cmd_op);
    assign base_w = 8'({cmd_head, cmd_unit});

    fdst_drive_status u_drive_status (
        .base     (base_w),
        .equipped (equip_mask[cmd_unit]),
        .media    (media_present[cmd_unit]),
        .wprot    (write_prot[cmd_unit]),
        .trk_zero (st_q.trk[cmd_unit] == '0),
        .status   (drv_stat_w)
    );

    fdst_seek_eval u_seek_eval (
        .base     (base_w),
        .is_recal (op_w == OP_RECAL),
        .equipped (equip_mask[cmd_unit]),
        .media    (media_present[cmd_unit]),
        .pend     (seek_pend_w),
        .move     (seek_move_w)
    );

    fdst_unit_scan #(.NUM_UNITS(NUM_UNITS)) u_unit_scan (
        .pend  (st_q.pend),
        .found (scan_found_w),
        .idx   (scan_idx_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.iclr = 1'b0;
        if (cmd_valid) begin
            unique case (op_w)
                OP_DRV_STAT: begin
                    st_d.vld = 1'b1;
                    st_d.cnt = 2'd1;
                    st_d.b0  = drv_stat_w;
                    st_d.b1  = 8'h00;
                end
                OP_SEEK, OP_RECAL: begin
                    st_d.pend[cmd_unit] = seek_pend_w;
                    if (seek_move_w)
                        st_d.trk[cmd_unit] = (op_w == OP_SEEK) ? cmd_cyl : '0;
                end
                OP_INT_STAT: begin
                    st_d.vld = 1'b1;
                    if (scan_found_w) begin
                        st_d.cnt              = 2'd2;
                        st_d.b0               = st_q.pend[scan_idx_w];
                        st_d.b1               = 8'(st_q.trk[scan_idx_w]);
                        st_d.pend[scan_idx_w] = 8'h00;
                    end else begin
                        st_d.cnt  = 2'd1;
                        st_d.b0   = INVALID_CMD;
                        st_d.b1   = 8'h00;
                        st_d.iclr = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign res_count = st_q.cnt;
    assign res_byte0 = st_q.b0;
    assign res_byte1 = st_q.b1;
    assign irq_clear = st_q.iclr;

    // R2: a result only follows an accepted sense command, one cycle later
    a_r2_result_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(cmd_valid) && ($past(cmd_op) == OP_DRV_STAT || $past(cmd_op) == OP_INT_STAT));

    // R2: sense commands always answer on the next cycle
    a_r2_sense_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_DRV_STAT || cmd_op == OP_INT_STAT)) |=> res_valid);

    // R10: a two-byte answer always carries a seek-end status
    a_r10_two_bytes_seek_end: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_count == 2'd2) |-> res_byte0[5]);

    // R11: interrupt clear only with the lone invalid byte
    a_r11_iclr_alone: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |-> res_valid && res_count == 2'd1 && res_byte0 == INVALID_CMD);

    // R6: a movable seek lands the track register in one step
    a_r6_seek_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SEEK && equip_mask[cmd_unit] && media_present[cmd_unit])
        |=> st_q.trk[$past(cmd_unit)] == $past(cmd_cyl));

    // R12: seek or recalibrate leaves a fresh pending status with seek end
    a_r12_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_SEEK || cmd_op == OP_RECAL))
        |=> st_q.pend[$past(cmd_unit)][5] && !res_valid);

endmodule

// File: tb/tb_fdst_tracker.sv
module tb_fdst_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [1:0] cmd_unit = 2'd0;
    logic       cmd_head = 1'b0;
    logic [7:0] cmd_cyl = 8'd0;
    logic [3:0] equip_mask = 4'b0000;
    logic [3:0] media_present = 4'b0000;
    logic [3:0] write_prot = 4'b0000;
    logic       res_valid;
    logic [1:0] res_count;
    logic [7:0] res_byte0;
    logic [7:0] res_byte1;
    logic       irq_clear;

    always #2 clk = ~clk;

    fdst_tracker dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_unit(cmd_unit), .cmd_head(cmd_head), .cmd_cyl(cmd_cyl),
        .equip_mask(equip_mask), .media_present(media_present), .write_prot(write_prot),
        .res_valid(res_valid), .res_count(res_count), .res_byte0(res_byte0),
        .res_byte1(res_byte1), .irq_clear(irq_clear)
    );

    typedef struct {
        logic [1:0] cnt;
        logic [7:0] b0;
        logic [7:0] b1;
        logic       iclr;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         n_run = 0;
    int         n_fail = 0;
    logic [7:0] m_pend[4];
    logic [7:0] m_trk[4];
    bit         mon_on = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pop one expectation per result
    always @(negedge clk) begin
        if (mon_on) begin
            if (res_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected result", {8'h0, res_byte0}, 16'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(res_count == e.cnt, e.tag, "count", 16'(res_count), 16'(e.cnt));
                    check(res_byte0 == e.b0, e.tag, "byte0", 16'(res_byte0), 16'(e.b0));
                    if (e.cnt == 2'd2)
                        check(res_byte1 == e.b1, e.tag, "byte1", 16'(res_byte1), 16'(e.b1));
                    check(irq_clear == e.iclr, e.tag, "irq_clear", 16'(irq_clear), 16'(e.iclr));
                end
            end else if (irq_clear) begin
                check(1'b0, "R11", "stray irq_clear", 16'h1, 16'h0);
            end
        end
    end

    // driver: model the command, push any expectation, then drive it
    task automatic issue(input logic [1:0] op, input int u, input logic h,
                         input logic [7:0] cyl, input string tag);
        logic [7:0] base;
        exp_t e;
        base   = {5'b0, h, 2'(u)};
        e.tag  = tag;
        e.b1   = 8'h00;
        e.iclr = 1'b0;
        case (op)
            2'd0: begin
                e.cnt = 2'd1;
                if (equip_mask[u])
                    e.b0 = base | 8'h08 | (m_trk[u] == 8'd0 ? 8'h10 : 8'h00)
                         | (media_present[u] ? 8'h20 : 8'h00) | (write_prot[u] ? 8'h40 : 8'h00);
                else
                    e.b0 = base | 8'h80;
                sb_q.push_back(e);
            end
            2'd1: begin
                if (equip_mask[u] && media_present[u]) begin
                    m_pend[u] = base | 8'h20;
                    m_trk[u]  = cyl;
                end else begin
                    m_pend[u] = base | 8'h68;
                end
            end
            2'd2: begin
                if (!equip_mask[u])        m_pend[u] = base | 8'h68;
                else if (!media_present[u]) m_pend[u] = base | 8'h28;
                else begin
                    m_pend[u] = base | 8'h20;
                    m_trk[u]  = 8'd0;
                end
            end
            default: begin
                int hit;
                hit = -1;
                for (int i = 3; i >= 0; i--) if (m_pend[i] != 8'd0) hit = i;
                if (hit >= 0) begin
                    e.cnt = 2'd2;
                    e.b0  = m_pend[hit];
                    e.b1  = m_trk[hit];
                    m_pend[hit] = 8'd0;
                end else begin
                    e.cnt  = 2'd1;
                    e.b0   = 8'h80;
                    e.iclr = 1'b1;
                end
                sb_q.push_back(e);
            end
        endcase
        @(negedge clk);
        cmd_op = op; cmd_unit = 2'(u); cmd_head = h; cmd_cyl = cyl; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    int  cyc = 0;
    bit  done = 1'b0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_pend[i] = 8'd0; m_trk[i] = 8'd0; end
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1", "res_valid in reset", 16'(res_valid), 16'h0);
        check(irq_clear == 1'b0, "R1", "irq_clear in reset", 16'(irq_clear), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0, "R1", "res_valid after reset", 16'(res_valid), 16'h0);
        mon_on = 1'b1;
        equip_mask = 4'b0011; media_present = 4'b0001; write_prot = 4'b0000;

        issue(2'd3, 0, 1'b0, 8'd0, "R1 nothing pending");
        issue(2'd0, 0, 1'b0, 8'd0, "R4 equipped track0");
        write_prot = 4'b0001;
        issue(2'd1, 0, 1'b0, 8'd5, "R6 seek move");
        issue(2'd0, 0, 1'b1, 8'd0, "R4 R3 wprot head1");
        issue(2'd0, 3, 1'b1, 8'd0, "R5 unequipped");
        issue(2'd0, 1, 1'b0, 8'd0, "R4 no media");
        issue(2'd1, 1, 1'b1, 8'd7, "R7 seek no media");
        issue(2'd2, 2, 1'b0, 8'd0, "R9 recal unequipped");
        issue(2'd3, 0, 1'b0, 8'd0, "R10 unit0 first");
        issue(2'd3, 0, 1'b0, 8'd0, "R10 R7 unit1 next");
        issue(2'd3, 0, 1'b0, 8'd0, "R10 unit2 last");
        issue(2'd3, 0, 1'b0, 8'd0, "R11 empty");

        issue(2'd2, 1, 1'b0, 8'd0, "R9 recal no media");
        media_present = 4'b0011;
        issue(2'd1, 1, 1'b0, 8'd9, "R12 replace");
        issue(2'd2, 0, 1'b0, 8'd0, "R8 recal move");
        issue(2'd3, 0, 1'b0, 8'd0, "R8 R10 unit0");
        issue(2'd3, 0, 1'b0, 8'd0, "R12 unit1");
        issue(2'd3, 0, 1'b0, 8'd0, "R11 empty again");
        issue(2'd0, 1, 1'b0, 8'd0, "R4 track nonzero");

        equip_mask = 4'b1111; media_present = 4'b1010; write_prot = 4'b0110;
        for (int k = 0; k < 24; k++) begin
            issue(2'(1 + (k % 2)), (k * 3) % 4, 1'(k / 3), 8'((k * 37 + 11) % 80), "R6 R7 sweep");
            if (k % 3 == 2) issue(2'd0, k % 4, 1'(k), 8'd0, "R4 sweep");
            if (k % 4 == 3) issue(2'd3, 0, 1'b0, 8'd0, "R10 sweep");
        end
        for (int k = 0; k < 5; k++) issue(2'd3, 0, 1'b0, 8'd0, "R10 R11 drain");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R2", "missing results", 16'(sb_q.size()), 16'h0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule